// File: doc/BRIEF.md
# Gated Read/Write Line Controller

This block drives the external read/write line of a processor bus adapter from the core's internal read/write signal. A gate input sets when the line tracks the core. While the gate is high the line follows the core. While the gate is low the line keeps the value it had when the gate fell. When the gate rises again the line shows the core's present value, which may differ from the held one, so a change can appear at that edge.

A bus-grant input decides whether the adapter may drive the line at all. The decision is made only at a rising gate edge, using the grant level seen just before that edge. A low grant there floats the line, and `rw_oe` drops so that a tri-state pad releases it. A high grant there drives the line again. All three inputs come through synchronizers on a fast system clock.

The float decision is held in a four-state machine:

| State | Meaning |
|---|---|
| ST_PASS | driving, gate high |
| ST_HOLD | driving, gate low |
| ST_FLOAT_PASS | floating, gate high |
| ST_FLOAT_WAIT | floating, gate low |

Its transitions are:

| Transition | Condition |
|---|---|
| ST_PASS to ST_HOLD | gate falls |
| ST_FLOAT_PASS to ST_FLOAT_WAIT | gate falls |
| ST_HOLD or ST_FLOAT_WAIT to ST_PASS | gate rises with prior grant high |
| ST_HOLD or ST_FLOAT_WAIT to ST_FLOAT_PASS | gate rises with prior grant low |

Reset enters ST_HOLD.

Top module: `rw_gate_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no input activity, `rw_oe` is 1 and `rw_out` is 1 (read). Reset places the machine in ST_HOLD with the held value at 1. Reset also treats the synchronized gate as 0, grant as 1 and core read/write as 1.
- R2: Each input passes through a two-flop synchronizer. A value present at clock edge n is first used by the logic after edge n+1.
- R3: While the synchronized gate is 1, `rw_out` equals the synchronized core read/write value, changing in the same cycle as it.
- R4: While the synchronized gate is 0, `rw_out` keeps the core value from the last cycle in which the gate was 1, and changes of the core input have no effect on it.
- R5: On the cycle in which the synchronized gate returns to 1, `rw_out` already shows the current synchronized core value, even if it differs from the held value.
- R6: A synchronized gate rise at which the grant seen in the previous cycle is 0 makes `rw_oe` 0 from the next clock on (ST_FLOAT_PASS).
- R7: While floating, a gate fall, or a gate rise with the prior grant 0, leaves `rw_oe` at 0.
- R8: A synchronized gate rise at which the prior-cycle grant is 1 makes `rw_oe` 1 from the next clock on (ST_PASS).
- R9: Changes of the grant input while the gate is steady, high or low, never change `rw_oe`.
- R10: When grant and gate rise in the same synchronized cycle after the grant was 0, the rise counts as a rise with grant low, and the line floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| gate_in | input | 1 | gate: 1 = pass core value, 0 = hold |
| grant_in | input | 1 | bus grant: 1 = adapter may drive the bus |
| core_rw_in | input | 1 | core read/write, 1 = read |
| rw_out | output | 1 | read/write line value, meaningful when rw_oe = 1 |
| rw_oe | output | 1 | pad output enable, 1 = drive, 0 = float |

## Verification
The bench runs a behavioural model of the input delay, the hold value and the float flag, and compares both outputs against it on every cycle.

The stimulus patterns each separate one behaviour from its neighbours:
- Core toggles while the gate is high separate pass-through from holding.
- Core toggles while the gate is low expose any leak through the hold.
- A gate rise carrying a different core value shows that the release is immediate.
- Grant changes while the gate is steady show that the enable moves only at a rise.
- Gate rises with grant low, then high, separate entering, keeping and leaving the float state.
- A simultaneous rise of grant and gate checks that the grant is taken from the cycle before the edge.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

    typedef enum logic [1:0] {
        ST_PASS       = 2'd0,
        ST_HOLD       = 2'd1,
        ST_FLOAT_PASS = 2'd2,
        ST_FLOAT_WAIT = 2'd3
    } rwg_state_t;

    // bit positions inside the synchronized input bundle
    localparam int unsigned SYNC_GATE  = 0;
    localparam int unsigned SYNC_GRANT = 1;
    localparam int unsigned SYNC_RW    = 2;
    localparam int unsigned SYNC_W     = 3;

endpackage

// File: rtl/rwg_sync.sv
module rwg_sync #(
    parameter int unsigned          WIDTH   = 3,
    parameter int unsigned          STAGES  = 2,
    parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rwg_fsm.sv
module rwg_fsm
    import rwg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_gate,
    input  logic s_grant,
    output logic gate_rise,
    output logic drive_en
);

    rwg_state_t state_q, state_d;
    logic       grant_d;
    logic       gate_was_low;

    // grant as seen one cycle before any detected gate edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant_d <= 1'b1;
        else        grant_d <= s_grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    assign gate_was_low = (state_q == ST_HOLD) || (state_q == ST_FLOAT_WAIT);
    assign gate_rise    = s_gate && gate_was_low;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS:       if (!s_gate) state_d = ST_HOLD;
            ST_FLOAT_PASS: if (!s_gate) state_d = ST_FLOAT_WAIT;
            ST_HOLD,
            ST_FLOAT_WAIT: if (s_gate)  state_d = grant_d ? ST_PASS : ST_FLOAT_PASS;
            default:                    state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_PASS, ST_HOLD:             drive_en = 1'b1;
            ST_FLOAT_PASS, ST_FLOAT_WAIT: drive_en = 1'b0;
            default:                      drive_en = 1'b1;
        endcase
    end

    // R6
    float_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_rise && !grant_d) |=> !drive_en);

    // R8
    drive_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_rise && grant_d) |=> drive_en);

    // R9
    enable_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_rise |=> $stable(drive_en));

endmodule

// File: rtl/rwg_hold.sv
module rwg_hold #(
    parameter logic RESET_RW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_gate,
    input  logic s_rw,
    output logic rw_line
);

    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= RESET_RW;
        else if (s_gate) hold_q <= s_rw;
    end

    // transparent while gate high, holding while low
    assign rw_line = s_gate ? s_rw : hold_q;

    // R4
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_gate && !$past(s_gate)) |-> $stable(rw_line));

    // R4
    hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_gate) |-> (rw_line == $past(s_rw)));

endmodule

// File: rtl/rw_gate_ctrl.sv
module rw_gate_ctrl
    import rwg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        RESET_RW    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic grant_in,
    input  logic core_rw_in,
    output logic rw_out,
    output logic rw_oe
);

    localparam logic [SYNC_W-1:0] SYNC_RST = {RESET_RW, 1'b1, 1'b0};

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              gate_rise;

    assign raw_bus[SYNC_GATE]  = gate_in;
    assign raw_bus[SYNC_GRANT] = grant_in;
    assign raw_bus[SYNC_RW]    = core_rw_in;

    rwg_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    rwg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_gate    (sync_bus[SYNC_GATE]),
        .s_grant   (sync_bus[SYNC_GRANT]),
        .gate_rise (gate_rise),
        .drive_en  (rw_oe)
    );

    rwg_hold #(
        .RESET_RW (RESET_RW)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_gate  (sync_bus[SYNC_GATE]),
        .s_rw    (sync_bus[SYNC_RW]),
        .rw_line (rw_out)
    );

    // R1
    known_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({rw_out, rw_oe, gate_rise}));

endmodule

// File: tb/tb_rw_gate_ctrl.sv
module tb_rw_gate_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_in = 1'b0;
    logic grant_in = 1'b1;
    logic core_rw_in = 1'b1;
    logic rw_out, rw_oe;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rw_gate_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_in    (gate_in),
        .grant_in   (grant_in),
        .core_rw_in (core_rw_in),
        .rw_out     (rw_out),
        .rw_oe      (rw_oe)
    );

    // behavioural reference: input history plus float flag and held value
    bit in_g = 1'b0, in_a = 1'b1, in_r = 1'b1;  // inputs seen at the previous edge
    bit sg0 = 1'b0, sg1 = 1'b0;                 // synchronized gate now / one cycle ago
    bit sa0 = 1'b1, sa1 = 1'b1;                 // synchronized grant now / one cycle ago
    bit sr0 = 1'b1;                             // synchronized core rw now
    bit m_float = 1'b0;
    bit m_hold  = 1'b1;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            in_g = 1'b0; in_a = 1'b1; in_r = 1'b1;
            sg0 = 1'b0; sg1 = 1'b0; sa0 = 1'b1; sa1 = 1'b1; sr0 = 1'b1;
            m_float = 1'b0; m_hold = 1'b1;
        end else begin
            if (sg0 && !sg1) m_float = !sa1;
            if (sg0) m_hold = sr0;
            sg1 = sg0; sa1 = sa0;
            sg0 = in_g; sa0 = in_a; sr0 = in_r;
            in_g = gate_in; in_a = grant_in; in_r = core_rw_in;
        end
    end

    task automatic compare(input string tag);
        bit exp_out, exp_oe;
        exp_oe  = !m_float;
        exp_out = sg0 ? sr0 : m_hold;
        checks++;
        if (rw_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s rw_oe actual=%b expected=%b at cycle %0d", tag, rw_oe, exp_oe, cyc);
        end
        checks++;
        if (rw_out !== exp_out) begin
            errors++;
            $display("FAIL %s rw_out actual=%b expected=%b at cycle %0d", tag, rw_out, exp_out, cyc);
        end
    endtask

    task automatic step(input bit g, input bit a, input bit r, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare(tag);
            gate_in = g; grant_in = a; core_rw_in = r;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state
        step(0, 1, 1, 4, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 1, 1, 4, "R1");

        // R3 / R2: gate high, core toggling slowly then every cycle
        step(1, 1, 1, 4, "R3");
        step(1, 1, 0, 4, "R3");
        step(1, 1, 1, 1, "R2");
        step(1, 1, 0, 1, "R2");
        step(1, 1, 1, 1, "R2");
        step(1, 1, 0, 3, "R2");

        // R4: gate low, core changes must not reach the line
        step(0, 1, 0, 3, "R4");
        step(0, 1, 1, 4, "R4");
        step(0, 1, 0, 1, "R4");
        step(0, 1, 1, 2, "R4");

        // R5: release shows the new core value at once
        step(1, 1, 1, 4, "R5");

        // R6: gate rise with grant low floats the line
        step(0, 1, 1, 3, "R6");
        step(0, 0, 1, 3, "R6");
        step(1, 0, 0, 4, "R6");

        // R7: float kept through a fall and a rise with grant low
        step(0, 0, 1, 3, "R7");
        step(1, 0, 1, 3, "R7");
        step(0, 1, 0, 3, "R7");

        // R8: rise with grant high restores drive
        step(1, 1, 1, 4, "R8");

        // R9: grant toggling with gate steady high, then steady low
        step(1, 0, 1, 3, "R9");
        step(1, 1, 0, 3, "R9");
        step(1, 0, 0, 2, "R9");
        step(0, 0, 1, 3, "R9");
        step(0, 1, 1, 3, "R9");
        step(0, 0, 0, 3, "R9");

        // R10: grant and gate rise together after grant low -> float
        step(0, 0, 1, 4, "R10");
        step(1, 1, 1, 5, "R10");
        step(0, 1, 1, 3, "R8");
        step(1, 1, 0, 5, "R8");
        step(1, 1, 0, 2, "R3");

        finish_run();
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

endmodule